// File: doc/BRIEF.md
# Four-Lane Bit-Interleaved Justification Multiplexer

The block takes four serial tributaries, each with its own clock, and merges them into one aggregate serial stream clocked by the local output clock. The four input clocks run near the same nominal rate but are not locked to one another or to the output clock. The output runs slightly faster than four times that nominal rate. The block therefore sometimes withholds a bit from a tributary and sends a marked filler bit in its place. This lets every tributary be carried without loss, whatever its exact rate inside the allowed band.

Each tributary lands in a small elastic buffer of its own. The write pointer crosses into the output domain in Gray code. An 848-bit frame counter in the output domain lays out the fixed overhead slots: the alignment word, an alarm bit, a spare bit and three groups of control bits. It fills every remaining slot with one bit per tributary in turn. Once per frame the fill level of each buffer is sampled. A tributary whose buffer sits below half depth gets a filler bit in its justification slot for that frame, and the control bits of the frame announce this three times so that the receiver can take a majority vote.

Top module: `jmux4`

## Requirements
- R1: Each frame is 848 output bits. Positions 0 to 9 carry 1111010000, sent leftmost first. Position 10 carries `alm_in` as sampled by the output clock edge that loads that bit. Position 11 is always 1.
- R2: Positions 212+t, 424+t and 636+t (t = 0..3) each carry lane t's justification flag for the current frame, where 1 means stuffed. All three copies in a frame are equal.
- R3: Position 640+t is lane t's justification slot. It carries 1 when lane t is stuffed in that frame, and otherwise the next bit of lane t.
- R4: Every other position is a data slot for lane (position mod 4). Each lane's bits leave in arrival order, with none lost, repeated or slipped, and at most one lane's buffer is read per output clock.
- R5: When the frame bit at position 11 is loaded, a live block samples each lane's fill level. A lane whose fill is below DEPTH/2 is stuffed in that frame, and the flags do not change at any other point in the frame.
- R6: Each lane buffer holds DEPTH bits (default 16). For lane rates between 205/848 and 206/848 of the output rate, it neither overflows nor is read while empty.
- R7: After reset the block is idle. It sends framed output whose data, justification and control bits are all 1, until every lane's fill reaches DEPTH/2 (checked on every clock). From then on it stays live. The frame in which it goes live keeps all four lanes stuffed.
- R8: While `rst_n` is low, `ser_out` is 1. Reset is released through a two-stage synchronizer, so frame bit 0 appears on `ser_out` after the third rising `clk` edge following the release.
- R9: The loop actually switches: over a long run at rates inside the band, every lane sees both stuffed and unstuffed frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output (aggregate) bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronized per clock domain inside |
| trib_clk | input | 4 | One clock per tributary lane; data is sampled on its rising edge |
| trib_dat | input | 4 | One serial data bit per tributary lane |
| alm_in | input | 1 | Alarm value placed in frame bit 10 |
| ser_out | output | 1 | Aggregate serial output, one bit per `clk` |

## Verification
The four lanes run at four different periods inside the allowed band. The fastest lane needs filler only occasionally and the slowest needs it in most frames, so the stuffing decision is exercised at both ends of its range. Each lane first sends a run of zeros and then a pseudo-random payload that begins with a 1. The zeros make the idle all-ones output distinguishable from real data. The payload lets the bench's own demultiplexer detect any dropped, repeated or misplaced bit by comparing the recovered sequence against what was sent. The alarm input changes from frame to frame, which shows that bit 10 follows it and not a fixed value.

// File: rtl/jmux_pkg.sv
`timescale 1ns/1ps
package jmux_pkg;
  localparam int NTRIB      = 4;
  localparam int LANE_W     = $clog2(NTRIB);
  localparam int FRAME_LEN  = 848;
  localparam int POS_W      = $clog2(FRAME_LEN);
  localparam int FAW_LEN    = 10;
  localparam int FAW_W      = $clog2(FAW_LEN);
  localparam logic [FAW_LEN-1:0] FAW_WORD = 10'b1111010000;
  localparam int ALM_POS    = 10;
  localparam int SPARE_POS  = 11;
  localparam int DECIDE_POS = SPARE_POS;
  localparam int CTL_POS_A  = 212;
  localparam int CTL_POS_B  = 424;
  localparam int CTL_POS_C  = 636;
  localparam int JUST_POS   = 640;

  typedef enum logic [2:0] {
    SK_FAW, SK_ALM, SK_SPARE, SK_CTL, SK_JUST, SK_DATA
  } slot_kind_e;

  typedef struct packed {
    slot_kind_e         kind;
    logic [LANE_W-1:0]  lane;
    logic [FAW_W-1:0]   faw_idx;
  } slot_t;
endpackage

// File: rtl/jmux_rst_sync.sv
`timescale 1ns/1ps
module jmux_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sh_q;
  logic [1:0] sh_d;

  always_comb sh_d = {sh_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[1];
endmodule

// File: rtl/jmux_frame_timer.sv
`timescale 1ns/1ps
module jmux_frame_timer
  import jmux_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  output logic [POS_W-1:0] pos_q,
  output slot_t            slot
);
  logic [POS_W-1:0] pos_d;

  function automatic logic in_win(input logic [POS_W-1:0] p, input int base);
    return (int'(p) >= base) && (int'(p) < base + NTRIB);
  endfunction

  always_comb begin
    if (pos_q == POS_W'(FRAME_LEN - 1)) pos_d = '0;
    else                                pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  // Overhead groups start on multiples of four, so the low bits name the lane.
  always_comb begin
    slot.kind    = SK_DATA;
    slot.lane    = pos_q[LANE_W-1:0];
    slot.faw_idx = pos_q[FAW_W-1:0];
    if (int'(pos_q) < FAW_LEN)          slot.kind = SK_FAW;
    else if (int'(pos_q) == ALM_POS)    slot.kind = SK_ALM;
    else if (int'(pos_q) == SPARE_POS)  slot.kind = SK_SPARE;
    else if (in_win(pos_q, CTL_POS_A) || in_win(pos_q, CTL_POS_B) ||
             in_win(pos_q, CTL_POS_C))  slot.kind = SK_CTL;
    else if (in_win(pos_q, JUST_POS))   slot.kind = SK_JUST;
  end
endmodule

// File: rtl/jmux_elastic.sv
`timescale 1ns/1ps
module jmux_elastic #(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic        wclk,
  input  logic        wrst_n,
  input  logic        wdat,
  input  logic        rclk,
  input  logic        rrst_n,
  input  logic        rd_en,
  output logic        rdat,
  output logic [AW:0] fill
);
  logic [DEPTH-1:0] mem_q;
  logic [AW:0]      wbin_q, wbin_d, wgray_q, wgray_d;
  logic [AW:0]      gs1_q, gs2_q, rbin_q, rbin_d, wsync_bin;

  function automatic logic [AW:0] gray2bin(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write side, tributary clock domain
  always_comb begin
    wbin_d  = wbin_q + 1'b1;
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  always_ff @(posedge wclk) begin
    if (wrst_n) mem_q[wbin_q[AW-1:0]] <= wdat;
  end

  // read side, output clock domain
  always_comb begin
    wsync_bin = gray2bin(gs2_q);
    rbin_d    = rd_en ? rbin_q + 1'b1 : rbin_q;
    fill      = wsync_bin - rbin_q;
    rdat      = mem_q[rbin_q[AW-1:0]];
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      gs1_q  <= '0;
      gs2_q  <= '0;
      rbin_q <= '0;
    end else begin
      gs1_q  <= wgray_q;
      gs2_q  <= gs1_q;
      rbin_q <= rbin_d;
    end
  end
endmodule

// File: rtl/jmux4.sv
`timescale 1ns/1ps
module jmux4
  import jmux_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIB-1:0] trib_clk,
  input  logic [NTRIB-1:0] trib_dat,
  input  logic             alm_in,
  output logic             ser_out
);
  localparam logic [AW:0] HALF = (AW+1)'(DEPTH / 2);

  logic                       orst_n;
  logic [NTRIB-1:0]           trst_n;
  logic [POS_W-1:0]           pos_q;
  slot_t                      slot;
  logic [NTRIB-1:0][AW:0]     fill;
  logic [NTRIB-1:0]           rd_en, rdat, low;
  logic [NTRIB-1:0]           stuff_q, stuff_d;
  logic                       live_q, live_d, all_half;
  logic                       ser_q, ser_d;

  jmux_rst_sync u_orst (.clk(clk), .arst_n(rst_n), .srst_n(orst_n));

  jmux_frame_timer u_timer (.clk(clk), .rst_n(orst_n), .pos_q(pos_q), .slot(slot));

  for (genvar g = 0; g < NTRIB; g++) begin : g_lane
    jmux_rst_sync u_trst (.clk(trib_clk[g]), .arst_n(rst_n), .srst_n(trst_n[g]));

    jmux_elastic #(.DEPTH(DEPTH)) u_buf (
      .wclk  (trib_clk[g]),
      .wrst_n(trst_n[g]),
      .wdat  (trib_dat[g]),
      .rclk  (clk),
      .rrst_n(orst_n),
      .rd_en (rd_en[g]),
      .rdat  (rdat[g]),
      .fill  (fill[g])
    );

    assign low[g] = fill[g] < HALF;
  end

  // justification decision and start-up gate
  always_comb begin
    all_half = ~|low;
    live_d   = live_q | all_half;
    stuff_d  = stuff_q;
    if (int'(pos_q) == DECIDE_POS) stuff_d = live_q ? low : '1;
  end

  always_ff @(posedge clk or negedge orst_n) begin
    if (!orst_n) begin
      live_q  <= 1'b0;
      stuff_q <= '1;
    end else begin
      live_q  <= live_d;
      stuff_q <= stuff_d;
    end
  end

  // buffer read strobes and output bit selection
  always_comb begin
    rd_en = '0;
    if (live_q && (slot.kind == SK_DATA ||
                   (slot.kind == SK_JUST && !stuff_q[slot.lane])))
      rd_en[slot.lane] = 1'b1;

    unique case (slot.kind)
      SK_FAW:   ser_d = FAW_WORD[FAW_W'(FAW_LEN - 1) - slot.faw_idx];
      SK_ALM:   ser_d = alm_in;
      SK_SPARE: ser_d = 1'b1;
      SK_CTL:   ser_d = stuff_q[slot.lane];
      SK_JUST:  ser_d = stuff_q[slot.lane] | !live_q | rdat[slot.lane];
      SK_DATA:  ser_d = !live_q | rdat[slot.lane];
      default:  ser_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge orst_n) begin
    if (!orst_n) ser_q <= 1'b1;
    else         ser_q <= ser_d;
  end

  assign ser_out = ser_q;
endmodule

// File: rtl/jmux4_chk.sv
`timescale 1ns/1ps
module jmux4_chk
  import jmux_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ser_out,
  input logic [POS_W-1:0]       pos_q,
  input logic [NTRIB-1:0]       stuff_q,
  input logic                   live_q,
  input logic [NTRIB-1:0]       rd_en,
  input logic [NTRIB-1:0][AW:0] fill
);
  // R1: the alignment word opens with a one
  assert_faw_lead_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == '0) |=> ser_out);

  // R4: a single lane is read per output bit
  assert_one_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_en));

  // R5: flags move only on the edge that loads frame bit 11
  assert_stuff_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != POS_W'(DECIDE_POS + 1)) |-> $stable(stuff_q));

  // R7: once live, always live; idle never reads
  assert_live_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |=> live_q);
  assert_idle_noread_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !live_q |-> (rd_en == '0));

  for (genvar g = 0; g < NTRIB; g++) begin : g_lane_chk
    // R6: buffers stay within bounds
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fill[g] <= (AW+1)'(DEPTH));
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en[g] |-> (fill[g] != '0));
    // R3: a stuffed justification slot carries a one
    assert_stuffed_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_q == POS_W'(JUST_POS + g) && stuff_q[g]) |=> ser_out);
    // R2: the first control copy carries the lane's flag
    assert_ctl_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_q == POS_W'(CTL_POS_A + g)) |=> (ser_out == $past(stuff_q[g])));
  end
endmodule

bind jmux4 jmux4_chk #(.DEPTH(DEPTH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ser_out(ser_out),
  .pos_q  (pos_q),
  .stuff_q(stuff_q),
  .live_q (live_q),
  .rd_en  (rd_en),
  .fill   (fill)
);

// File: tb/tb_jmux4.sv
`timescale 1ns/1ps
module tb_jmux4;
  import jmux_pkg::*;

  localparam int DEPTH    = 16;
  localparam int NFRAMES  = 150;
  localparam int PRE_BITS = 60;
  localparam int WDOG     = 190000;

  logic             clk, rst_n, alm_in, ser_out;
  logic [NTRIB-1:0] trib_clk, trib_dat;

  int   n_chk, n_fail;
  logic expq [NTRIB][$];
  bit   done;

  jmux4 #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .trib_clk(trib_clk), .trib_dat(trib_dat),
    .alm_in(alm_in), .ser_out(ser_out)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Lane source: zeros first, then a payload that opens with a one.
  task automatic drive_lane(input int t, input realtime hp, input logic [15:0] seed);
    logic [15:0] lf;
    logic        b;
    int          n;
    lf = seed;
    n  = 0;
    trib_clk[t] = 1'b0;
    trib_dat[t] = 1'b0;
    forever begin
      #(hp) trib_clk[t] = 1'b1;
      #(hp) trib_clk[t] = 1'b0;
      if (n >= PRE_BITS) begin
        b  = (n == PRE_BITS) ? 1'b1 : lf[0];
        lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
        trib_dat[t] = b;
        expq[t].push_back(b);
      end
      n++;
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WDOG, NFRAMES * FRAME_LEN);
      report();
      $finish;
    end
  end

  initial begin
    int   state [NTRIB];
    int   nstuff [NTRIB];
    int   nplain [NTRIB];
    int   nrec [NTRIB];
    logic ctl [NTRIB][3];
    logic alm_exp;
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; alm_in = 1'b0; alm_exp = 1'b0;
    for (int t = 0; t < NTRIB; t++) begin
      state[t] = 0; nstuff[t] = 0; nplain[t] = 0; nrec[t] = 0;
    end
    fork
      drive_lane(0, 16.480, 16'hACE1);
      drive_lane(1, 16.500, 16'h1D2B);
      drive_lane(2, 16.520, 16'h5A5A);
      drive_lane(3, 16.535, 16'h0F31);
    join_none

    repeat (10) @(negedge clk);
    chk(ser_out === 1'b1, "R8 output high in reset", int'(ser_out), 1);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int k = 0; k < NFRAMES * FRAME_LEN; k++) begin
      int   p, fr, t;
      logic b;
      bit   is_data;
      @(negedge clk);
      b = ser_out; p = k % FRAME_LEN; fr = k / FRAME_LEN;
      is_data = 1'b0; t = p % NTRIB;
      if (p < FAW_LEN)
        chk(b == FAW_WORD[FAW_LEN-1-p], "R1 alignment word", int'(b), int'(FAW_WORD[FAW_LEN-1-p]));
      else if (p == ALM_POS)
        chk(b == alm_exp, "R1 alarm bit", int'(b), int'(alm_exp));
      else if (p == SPARE_POS)
        chk(b == 1'b1, "R1 spare bit", int'(b), 1);
      else if ((p >= CTL_POS_A && p < CTL_POS_A + NTRIB) ||
               (p >= CTL_POS_B && p < CTL_POS_B + NTRIB) ||
               (p >= CTL_POS_C && p < CTL_POS_C + NTRIB)) begin
        ctl[t][(p < CTL_POS_B) ? 0 : (p < CTL_POS_C) ? 1 : 2] = b;
        if (fr == 0) chk(b == 1'b1, "R7 idle control bit", int'(b), 1);
      end else if (p >= JUST_POS && p < JUST_POS + NTRIB) begin
        int votes;
        votes = int'(ctl[t][0]) + int'(ctl[t][1]) + int'(ctl[t][2]);
        chk(votes == 0 || votes == 3, "R2 control copies agree", votes, 3);
        if (fr == 0) chk(b == 1'b1, "R7 idle justification", int'(b), 1);
        if (votes >= 2) begin
          chk(b == 1'b1, "R3 stuff bit is one", int'(b), 1);
          if (fr >= 2) nstuff[t]++;
        end else begin
          is_data = 1'b1;
          if (fr >= 2) nplain[t]++;
        end
      end else begin
        is_data = 1'b1;
        if (fr == 0 && p < 16) chk(b == 1'b1, "R7 idle data is ones", int'(b), 1);
      end

      if (is_data) begin
        if (state[t] == 0 && b == 1'b0) state[t] = 1;
        else if (state[t] == 1 && b == 1'b1) state[t] = 2;
        if (state[t] == 2) begin
          if (expq[t].size() == 0)
            chk(1'b0, "R4 lane bit without source", nrec[t], nrec[t] - 1);
          else begin
            logic e;
            e = expq[t].pop_front();
            chk(b == e, "R4 lane order", int'(b), int'(e));
            nrec[t]++;
          end
        end
      end

      if (p == 400) begin
        alm_in  = (fr % 3) != 1;
        alm_exp = alm_in;
      end
    end

    for (int t = 0; t < NTRIB; t++) begin
      chk(nrec[t] >= (NFRAMES - 3) * 200, "R4 R6 lane throughput", nrec[t], (NFRAMES - 3) * 200);
      chk(nstuff[t] > 0, "R5 R9 stuffed frames seen", nstuff[t], 1);
      chk(nplain[t] > 0, "R5 R9 unstuffed frames seen", nplain[t], 1);
    end
    done = 1'b1;
    report();
    $finish;
  end
endmodule